// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetch Channel

This block is a single frame-fetch DMA channel for a display pipeline. Frame setup lives in memory as a linked list of 16-byte descriptors. On every frame start the channel chooses a descriptor address and reads the four descriptor words over a request/valid memory port. It then hands the frame's source address, identifier and command word to the pixel fetch logic, which is outside this block. Software can steer the chain through a branch register. If that register holds a pending request, the next descriptor is taken from the branch address instead of the stored link, and the request bit then clears itself.

Addresses are checked against a memory window set by parameters. A descriptor that would fall outside the window is not fetched. A frame whose source address is zero or outside the window raises a bus-error strobe instead of a start-of-frame strobe. Branch, start-of-frame, end-of-frame and bus-error events each leave the block as one-cycle strobes for an interrupt collector elsewhere.

Top module: `frame_desc_dma`

## Requirements
- R1: After reset every readable register reads zero, `busy`, `mem_req`, `frame_ok` and all four strobes are low.
- R2: The link register sits at offset 0x200 + 16*CHAN + 0x0. A write stores the data with its low four bits forced to zero (mask 0xFFFFFFF0). Source (+0x4), identifier (+0x8) and command (+0xC) read back their loaded values, and writes to them are ignored.
- R3: The branch register sits at offset BRANCH_OFS (default 0x020). A write stores the data masked with 0xFFFFFFF3. Bit 0 is the request flag, bit 1 is the strobe-enable flag and bits 31:4 are the branch address.
- R4: A frame start clears the source register. When `chan_en` is low, nothing else happens: no memory request, no strobe, and the branch register is left unchanged.
- R5: On an enabled frame start with the branch request flag set, the descriptor pointer is the branch address with its low four bits zero. Only bit 0 of the branch register is cleared. `branch_stb` pulses once if bit 1 is set. With the flag clear, the link register is used as the pointer.
- R6: The four words are read from pointer, +4, +8 and +12, in that order, with one request outstanding at a time. They load the link, source, identifier and command registers in that order.
- R7: A pointer P with P < MEM_BASE or P+16 > MEM_BASE+MEM_SIZE causes no memory request and one `ber_stb` pulse.
- R8: After the load, a source of zero, a source below MEM_BASE or a source above MEM_BASE+MEM_SIZE gives one `ber_stb` pulse and no `sof_stb`. MEM_BASE+MEM_SIZE itself counts as valid.
- R9: After a load with a valid source, `frame_ok` rises. `sof_stb` pulses once exactly when command bit 22 is set.
- R10: A `frame_done` pulse gives one `eof_stb` pulse exactly when `frame_ok` is high and command bit 21 is set.
- R11: A frame start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable, sampled at frame start |
| frame_start | input | 1 | One-cycle frame start pulse |
| frame_done | input | 1 | One-cycle frame completion pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory word request, held until valid |
| mem_addr | output | 32 | Memory word address |
| mem_valid | input | 1 | Memory returns a word this cycle |
| mem_rdata | input | 32 | Memory word data |
| src_addr | output | 32 | Frame source address |
| frame_id | output | 32 | Frame identifier |
| frame_cmd | output | 32 | Frame command word |
| frame_ok | output | 1 | Current frame loaded with a valid source |
| busy | output | 1 | Descriptor load in progress |
| branch_stb | output | 1 | Branch taken with strobe enabled |
| sof_stb | output | 1 | Start-of-frame strobe |
| eof_stb | output | 1 | End-of-frame strobe |
| ber_stb | output | 1 | Bus-error strobe |

## Verification
Random frames mix descriptors reached through the link and through the branch register, with and without the branch strobe flag. The source word is drawn as zero, just below the window, just above it, or inside it, and command bits are random. This separates the pointer-selection path from the source check and the strobe gating. Memory latency varies from zero to two cycles, which tests whether the request holds its address and whether the beats arrive in ascending order. Directed frames put the pointer exactly on the last fitting slot and one slot past it, and put the source exactly on the window end. They also cover a disabled channel, and a second frame start sent while a load is in progress.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CHECK = 2'd2
    } fstate_e;

    typedef struct packed {
        logic [4:0]  rsv_hi;
        logic        pal_load;
        logic [2:0]  rsv_mid;
        logic        sof_en;
        logic        eof_en;
        logic [18:0] len_words;
        logic [1:0]  rsv_lo;
    } cmd_t;

    typedef struct packed {
        logic [27:0] addr;
        logic [1:0]  rsv;
        logic        irq;
        logic        req;
    } branch_t;

    localparam logic [31:0] LINK_WR_MASK   = 32'hFFFF_FFF0;
    localparam logic [31:0] BRANCH_WR_MASK = 32'hFFFF_FFF3;
    localparam int          DESC_WORDS     = 4;
    localparam int          DESC_BYTES     = 4 * DESC_WORDS;

    function automatic logic desc_fits(input logic [31:0] p,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
        logic [32:0] p_end;
        logic [32:0] w_end;
        p_end = {1'b0, p} + 33'(DESC_BYTES);
        w_end = {1'b0, base} + {1'b0, size};
        return (p >= base) && (p_end <= w_end);
    endfunction

    function automatic logic src_valid(input logic [31:0] s,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
        logic [32:0] w_end;
        w_end = {1'b0, base} + {1'b0, size};
        return (s != 32'd0) && (s >= base) && ({1'b0, s} <= w_end);
    endfunction

endpackage

// File: rtl/fdma_regs.sv
module fdma_regs
    import fdma_pkg::*;
#(
    parameter int CHAN       = 0,
    parameter int AW         = 12,
    parameter int BRANCH_OFS = 'h020
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          clr_src,
    input  logic          clr_bra,
    input  logic          word_we,
    input  logic [1:0]    word_idx,
    input  logic [31:0]   word_data,
    output logic [31:0]   link_q,
    output logic [31:0]   src_q,
    output logic [31:0]   id_q,
    output logic [31:0]   cmd_q,
    output branch_t       branch_q
);
    localparam int          CH_BASE = 'h200 + 16 * CHAN;
    localparam logic [AW-1:0] A_LINK = AW'(CH_BASE);
    localparam logic [AW-1:0] A_SRC  = AW'(CH_BASE + 4);
    localparam logic [AW-1:0] A_ID   = AW'(CH_BASE + 8);
    localparam logic [AW-1:0] A_CMD  = AW'(CH_BASE + 12);
    localparam logic [AW-1:0] A_BRA  = AW'(BRANCH_OFS);

    logic wr_link, wr_bra;
    logic [31:0] words_q [DESC_WORDS];

    assign wr_link = reg_we && (reg_addr == A_LINK);
    assign wr_bra  = reg_we && (reg_addr == A_BRA);

    // one storage word per descriptor slot
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[g] <= '0;
            end else begin
                if (g == 1 && clr_src)
                    words_q[g] <= '0;
                if (word_we && word_idx == 2'(g))
                    words_q[g] <= word_data;
                if (g == 0 && wr_link)
                    words_q[g] <= reg_wdata & LINK_WR_MASK;
            end
        end
    end

    assign link_q = words_q[0];
    assign src_q  = words_q[1];
    assign id_q   = words_q[2];
    assign cmd_q  = words_q[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            branch_q <= '0;
        end else if (wr_bra) begin
            branch_q <= branch_t'(reg_wdata & BRANCH_WR_MASK);
        end else if (clr_bra) begin
            branch_q.req <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_LINK) reg_rdata = link_q;
        if (reg_addr == A_SRC)  reg_rdata = src_q;
        if (reg_addr == A_ID)   reg_rdata = id_q;
        if (reg_addr == A_CMD)  reg_rdata = cmd_q;
        if (reg_addr == A_BRA)  reg_rdata = branch_q;
    end

    p_src_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clr_src |=> (src_q == 32'd0));

    p_bra_selfclear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_bra && !wr_bra) |=> !branch_q.req);

endmodule

// File: rtl/fdma_fetch.sv
module fdma_fetch
    import fdma_pkg::*;
#(
    parameter logic [31:0] MEM_BASE = 32'h1000_0000,
    parameter logic [31:0] MEM_SIZE = 32'h0001_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        chan_en,
    input  logic        frame_start,
    input  logic [31:0] link_q,
    input  logic [31:0] src_q,
    input  branch_t     branch_q,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [31:0] mem_rdata,
    output logic        clr_src,
    output logic        clr_bra,
    output logic        word_we,
    output logic [1:0]  word_idx,
    output logic [31:0] word_data,
    output logic        busy,
    output logic        ev_branch,
    output logic        ev_ber,
    output logic        ev_load
);
    localparam logic [1:0] LAST_IDX = 2'(DESC_WORDS - 1);

    fstate_e     state_q;
    logic [31:0] ptr_q;
    logic [1:0]  idx_q;
    logic        start, go, fits, src_good;
    logic [31:0] next_ptr;

    assign start    = frame_start && (state_q == ST_IDLE);
    assign go       = start && chan_en;
    assign next_ptr = branch_q.req ? {branch_q.addr, 4'b0000} : link_q;
    assign fits     = desc_fits(next_ptr, MEM_BASE, MEM_SIZE);
    assign src_good = src_valid(src_q, MEM_BASE, MEM_SIZE);

    assign clr_src   = start;
    assign clr_bra   = go && branch_q.req;
    assign ev_branch = clr_bra && branch_q.irq;
    assign ev_ber    = (go && !fits) || (state_q == ST_CHECK && !src_good);
    assign ev_load   = (state_q == ST_CHECK) && src_good;

    assign mem_req   = (state_q == ST_FETCH);
    assign mem_addr  = ptr_q + {28'd0, idx_q, 2'b00};
    assign word_we   = mem_req && mem_valid;
    assign word_idx  = idx_q;
    assign word_data = mem_rdata;
    assign busy      = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go && fits) begin
                    ptr_q   <= next_ptr;
                    idx_q   <= '0;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: if (mem_valid) begin
                    idx_q <= idx_q + 2'd1;
                    if (idx_q == LAST_IDX) state_q <= ST_CHECK;
                end
                ST_CHECK: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    p_req_in_window_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr >= MEM_BASE &&
                     ({1'b0, mem_addr} + 33'd4) <= ({1'b0, MEM_BASE} + {1'b0, MEM_SIZE})));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_valid && idx_q != LAST_IDX) |=> (mem_req && mem_addr == $past(mem_addr) + 32'd4));

    p_ignore_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && frame_start) |-> !clr_src);

endmodule

// File: rtl/fdma_events.sv
module fdma_events
    import fdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_begin,
    input  logic        frame_done,
    input  logic        ev_branch,
    input  logic        ev_ber,
    input  logic        ev_load,
    input  logic [31:0] cmd_q,
    output logic        frame_ok,
    output logic        branch_stb,
    output logic        sof_stb,
    output logic        eof_stb,
    output logic        ber_stb
);
    cmd_t cmd;
    assign cmd = cmd_t'(cmd_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_ok   <= 1'b0;
            branch_stb <= 1'b0;
            sof_stb    <= 1'b0;
            eof_stb    <= 1'b0;
            ber_stb    <= 1'b0;
        end else begin
            branch_stb <= ev_branch;
            ber_stb    <= ev_ber;
            sof_stb    <= ev_load && cmd.sof_en;
            eof_stb    <= frame_done && frame_ok && cmd.eof_en;
            if (frame_begin)  frame_ok <= 1'b0;
            else if (ev_load) frame_ok <= 1'b1;
        end
    end

    p_sof_ber_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(sof_stb && ber_stb));

    p_sof_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        sof_stb |=> !sof_stb);

    p_eof_after_ok_r10: assert property (@(posedge clk) disable iff (rst)
        eof_stb |-> $past(frame_ok));

endmodule

// File: rtl/frame_desc_dma.sv
module frame_desc_dma
    import fdma_pkg::*;
#(
    parameter int          CHAN       = 0,
    parameter int          AW         = 12,
    parameter int          BRANCH_OFS = 'h020,
    parameter logic [31:0] MEM_BASE   = 32'h1000_0000,
    parameter logic [31:0] MEM_SIZE   = 32'h0001_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_en,
    input  logic          frame_start,
    input  logic          frame_done,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    input  logic          mem_valid,
    input  logic [31:0]   mem_rdata,
    output logic [31:0]   src_addr,
    output logic [31:0]   frame_id,
    output logic [31:0]   frame_cmd,
    output logic          frame_ok,
    output logic          busy,
    output logic          branch_stb,
    output logic          sof_stb,
    output logic          eof_stb,
    output logic          ber_stb
);
    logic        clr_src, clr_bra, word_we;
    logic [1:0]  word_idx;
    logic [31:0] word_data, link_q, src_q, id_q, cmd_q;
    branch_t     branch_q;
    logic        ev_branch, ev_ber, ev_load;

    fdma_regs #(.CHAN(CHAN), .AW(AW), .BRANCH_OFS(BRANCH_OFS)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clr_src(clr_src), .clr_bra(clr_bra),
        .word_we(word_we), .word_idx(word_idx), .word_data(word_data),
        .link_q(link_q), .src_q(src_q), .id_q(id_q), .cmd_q(cmd_q), .branch_q(branch_q)
    );

    fdma_fetch #(.MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE)) u_fetch (
        .clk(clk), .rst(rst), .chan_en(chan_en), .frame_start(frame_start),
        .link_q(link_q), .src_q(src_q), .branch_q(branch_q),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .clr_src(clr_src), .clr_bra(clr_bra),
        .word_we(word_we), .word_idx(word_idx), .word_data(word_data),
        .busy(busy), .ev_branch(ev_branch), .ev_ber(ev_ber), .ev_load(ev_load)
    );

    fdma_events u_events (
        .clk(clk), .rst(rst), .frame_begin(clr_src), .frame_done(frame_done),
        .ev_branch(ev_branch), .ev_ber(ev_ber), .ev_load(ev_load), .cmd_q(cmd_q),
        .frame_ok(frame_ok), .branch_stb(branch_stb), .sof_stb(sof_stb),
        .eof_stb(eof_stb), .ber_stb(ber_stb)
    );

    assign src_addr  = src_q;
    assign frame_id  = id_q;
    assign frame_cmd = cmd_q;

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !mem_req && !frame_ok && !sof_stb && !ber_stb));

endmodule

// File: tb/sim_frame_desc_dma.sv
module sim_frame_desc_dma;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam logic [31:0] SIZE = 32'h0001_0000;
    localparam logic [11:0] A_LINK = 12'h200, A_SRC = 12'h204, A_ID = 12'h208, A_CMD = 12'h20C;
    localparam logic [11:0] A_BRA = 12'h020;

    logic clk = 0, rst = 1, chan_en = 0, frame_start = 0, frame_done = 0;
    logic reg_we = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_req, mem_valid = 0;
    logic [31:0] mem_addr, mem_rdata = 0;
    logic [31:0] src_addr, frame_id, frame_cmd;
    logic frame_ok, busy, branch_stb, sof_stb, eof_stb, ber_stb;

    int checks = 0, fails = 0;
    int n_bra = 0, n_sof = 0, n_eof = 0, n_ber = 0, n_beats = 0;
    logic [31:0] beat_log [0:7];
    logic [31:0] mem [0:63];
    int lat = -1;
    logic [31:0] m_link = 0, m_id = 0, m_cmd = 0, m_src = 0;
    logic m_ok = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    frame_desc_dma u0 (
        .clk(clk), .rst(rst), .chan_en(chan_en), .frame_start(frame_start), .frame_done(frame_done),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .src_addr(src_addr), .frame_id(frame_id), .frame_cmd(frame_cmd), .frame_ok(frame_ok),
        .busy(busy), .branch_stb(branch_stb), .sof_stb(sof_stb), .eof_stb(eof_stb), .ber_stb(ber_stb)
    );

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (a >= BASE && a < BASE + 32'd256) return mem[(a - BASE) >> 2];
        return a ^ 32'hA5A5_5A5A;
    endfunction

    function automatic bit fits_tb(input logic [31:0] p);
        return p >= BASE && (64'(p) + 16) <= (64'(BASE) + 64'(SIZE));
    endfunction

    function automatic bit srcok_tb(input logic [31:0] s);
        return s != 0 && s >= BASE && 64'(s) <= (64'(BASE) + 64'(SIZE));
    endfunction

    // memory model and strobe monitor, away from the active edge
    always @(negedge clk) begin
        if (branch_stb) n_bra++;
        if (sof_stb) n_sof++;
        if (eof_stb) n_eof++;
        if (ber_stb) n_ber++;
        if (mem_valid) begin
            mem_valid = 0;
            lat = -1;
        end else if (mem_req) begin
            if (lat < 0) lat = int'($urandom % 3);
            if (lat == 0) begin
                mem_valid = 1;
                mem_rdata = mem_read(mem_addr);
                if (n_beats < 8) beat_log[n_beats] = mem_addr;
                n_beats++;
            end else lat--;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic clr_counts();
        n_bra = 0; n_sof = 0; n_eof = 0; n_ber = 0; n_beats = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 200) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
    endtask

    // run one enabled frame; ptr is the pointer the bench expects to be used
    task automatic run_frame(input logic [31:0] ptr, input bit via_bra, input bit bra_irq,
                             input logic [31:0] bra_after);
        logic [31:0] v, w1, w3;
        bit f;
        f = fits_tb(ptr);
        clr_counts();
        pulse_start();
        wait_idle();
        if (f) begin
            m_link = mem_read(ptr); w1 = mem_read(ptr + 4); m_id = mem_read(ptr + 8);
            w3 = mem_read(ptr + 12); m_cmd = w3; m_src = w1; m_ok = srcok_tb(w1);
            chk("R6 beats", 32'(n_beats), 4);
            for (int k = 0; k < 4; k++) chk("R6 beat order", beat_log[k], ptr + 32'(4 * k));
            rd(A_LINK, v); chk("R6 link load", v, m_link);
            rd(A_SRC, v);  chk("R6 source load", v, m_src);
            rd(A_ID, v);   chk("R6 id load", v, m_id);
            rd(A_CMD, v);  chk("R6 cmd load", v, m_cmd);
            chk("R8 bus error", 32'(n_ber), m_ok ? 0 : 1);
            chk("R9 sof", 32'(n_sof), (m_ok && w3[22]) ? 1 : 0);
            chk("R9 frame_ok", 32'(frame_ok), 32'(m_ok));
        end else begin
            m_src = 0; m_ok = 0;
            chk("R7 no request", 32'(n_beats), 0);
            chk("R7 bus error", 32'(n_ber), 1);
            chk("R7 sof none", 32'(n_sof), 0);
            rd(A_SRC, v); chk("R4 source cleared", v, 0);
            rd(A_LINK, v); chk("R7 link kept", v, m_link);
        end
        chk("R5 branch strobe", 32'(n_bra), (via_bra && bra_irq) ? 1 : 0);
        rd(A_BRA, v); chk("R5 branch reg after", v, bra_after);
        clr_counts();
        @(negedge clk); frame_done = 1;
        @(negedge clk); frame_done = 0;
        repeat (2) @(negedge clk);
        chk("R10 eof", 32'(n_eof), (m_ok && m_cmd[21]) ? 1 : 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog timeout");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, slot, br;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd(A_LINK, v); chk("R1 link", v, 0);
        rd(A_SRC, v);  chk("R1 src", v, 0);
        rd(A_ID, v);   chk("R1 id", v, 0);
        rd(A_CMD, v);  chk("R1 cmd", v, 0);
        rd(A_BRA, v);  chk("R1 branch", v, 0);
        chk("R1 outputs", {busy, mem_req, frame_ok, branch_stb, sof_stb, eof_stb, ber_stb}, 0);

        // R2 masking and read-only registers
        wr(A_LINK, 32'h1000_0127); rd(A_LINK, v); chk("R2 link mask", v, 32'h1000_0120);
        wr(A_SRC, 32'hDEAD_BEEF);  rd(A_SRC, v);  chk("R2 src read-only", v, 0);
        wr(A_CMD, 32'hDEAD_BEEF);  rd(A_CMD, v);  chk("R2 cmd read-only", v, 0);
        // R3 branch mask
        wr(A_BRA, 32'hFFFF_FFFF); rd(A_BRA, v); chk("R3 branch mask", v, 32'hFFFF_FFF3);
        wr(A_BRA, 32'h0);
        m_link = 32'h1000_0120;

        // directed valid frame, slot 0, source at window end (R8 boundary)
        chan_en = 1;
        mem[0] = BASE + 32'h10; mem[1] = BASE + SIZE; mem[2] = 32'h0000_0042; mem[3] = 32'h0060_0000;
        wr(A_LINK, BASE); m_link = BASE;
        run_frame(BASE, 0, 0, 0);

        // R4 disabled channel: source cleared, branch untouched, no activity
        chan_en = 0;
        wr(A_BRA, BASE | 32'h3);
        clr_counts();
        pulse_start(); repeat (4) @(negedge clk);
        chk("R4 no request", 32'(n_beats), 0);
        chk("R4 no strobes", 32'(n_bra + n_sof + n_ber), 0);
        rd(A_SRC, v); chk("R4 src cleared", v, 0);
        rd(A_BRA, v); chk("R4 branch kept", v, BASE | 32'h3);
        chan_en = 1;
        wr(A_BRA, 0);

        // R7 boundaries: last fitting slot and one past
        m_link = BASE + SIZE - 16; wr(A_LINK, m_link);
        run_frame(BASE + SIZE - 16, 0, 0, 0);
        m_link = BASE + SIZE; wr(A_LINK, m_link);
        run_frame(BASE + SIZE, 0, 0, 0);
        m_link = BASE - 16; wr(A_LINK, m_link);
        run_frame(BASE - 16, 0, 0, 0);

        // R11 frame start while busy is ignored
        mem[4] = 32'h0; mem[5] = BASE + 32'h100; mem[6] = 32'h7; mem[7] = 32'h0040_0000;
        wr(A_LINK, BASE + 32'h10);
        clr_counts();
        pulse_start();
        @(negedge clk); frame_start = 1; @(negedge clk); frame_start = 0;
        wait_idle(); repeat (6) @(negedge clk);
        chk("R11 single fetch", 32'(n_beats), 4);
        chk("R11 single sof", 32'(n_sof), 1);
        m_link = 32'h0; m_id = 32'h7; m_cmd = 32'h0040_0000;

        // random frames through link or branch
        for (int it = 0; it < 48; it++) begin
            bit via, irq;
            int sel;
            slot = BASE + 32'(($urandom % 16) * 16);
            mem[(slot - BASE) >> 2] = $urandom & 32'hFFFF_FFF0;
            sel = int'($urandom % 4);
            case (sel)
                0: mem[((slot - BASE) >> 2) + 1] = 32'h0;
                1: mem[((slot - BASE) >> 2) + 1] = BASE - 32'd4;
                2: mem[((slot - BASE) >> 2) + 1] = BASE + SIZE + 32'd4;
                default: mem[((slot - BASE) >> 2) + 1] = BASE + ($urandom % SIZE);
            endcase
            mem[((slot - BASE) >> 2) + 2] = $urandom;
            mem[((slot - BASE) >> 2) + 3] = $urandom;
            via = bit'($urandom % 2);
            irq = bit'($urandom % 2);
            if (via) begin
                m_link = BASE + SIZE + 32'h100; wr(A_LINK, m_link);
                br = slot | {30'd0, irq, 1'b1} | ($urandom & 32'h0000_0000);
                wr(A_BRA, br);
                run_frame(slot, 1, irq, br & 32'hFFFF_FFF2);
                wr(A_BRA, 0);
            end else begin
                m_link = slot; wr(A_LINK, slot);
                run_frame(slot, 0, 0, 0);
            end
        end

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule